// File: doc/BRIEF.md
# Reset and Start-up Delay Sequencer

This block generates the internal reset and the core hold of a small microcontroller core. It accepts three causes: a power-on reset indication, which is also the block's own synchronous active-low reset, an asynchronous active-low external reset pin, and a one-cycle wake request issued when the core leaves its halt state. For power-up and for halt wake-up it holds the core for a fixed start-up delay of system clocks, so that the oscillator can settle. A pin reset skips this delay: the core is released as soon as the synchronised pin returns high.

While the full-chip reset is active, a bundle of default-load strobes tells the rest of the core to take its reset state. The program counter goes to zero, interrupts are disabled, the prescaler is cleared, the watchdog is cleared, the timer is switched off, the ports are set to input and the stack pointer goes to the top of the stack. A separate run enable lets the watchdog count once the reset is released. A halt wake-up holds only the core. It does not pulse the full-chip reset. A two-bit status reports the cause of the most recent reset.

Top module: `startup_reset_seq`

## Requirements
- R1: While `rst_n` is sampled low, the next cycle shows `core_hold`=1, `chip_rst`=1 and `cause`=2'b01 (power-up).
- R2: After `rst_n` is sampled high, `core_hold` and `chip_rst` stay 1 for exactly 1024 clock edges. Both fall after the 1024th edge.
- R3: `ext_rst_n` is active low and passes through two synchroniser flops. A low level is seen at the third rising edge after it is applied. That edge sets `chip_rst`=1, `core_hold`=1 and `cause`=2'b10 (pin).
- R4: When `ext_rst_n` returns high, `core_hold` and `chip_rst` fall at the third rising edge, with no start-up delay.
- R5: A `wake_req` pulse while the core runs sets `core_hold`=1 for exactly 1024 edges and `cause`=2'b11 (wake-up). `chip_rst` stays 0 throughout.
- R6: A `wake_req` that arrives while a delay is running restarts the delay from zero. The hold then ends 1024 edges after that request.
- R7: A pin reset that arrives during a start-up delay abandons the delay and follows R3 and R4. The core is released well before 1024 edges.
- R8: `dflt_load` has its bits ordered as 0 program counter, 1 interrupt disable, 2 prescaler clear, 3 watchdog clear, 4 timer off, 5 port input mode and 6 stack pointer to top. All seven bits are 1 while `chip_rst` is 1 and 0 otherwise. `wdt_run` is the inverse of `chip_rst`.
- R9: A synchronised pin reset has priority over a simultaneous `wake_req`. The wake request is ignored, so `cause` becomes 2'b10, and release follows R4 with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset indication, synchronous, active low |
| ext_rst_n | input | 1 | External reset pin, asynchronous, active low |
| wake_req | input | 1 | One-cycle wake-up request from halt |
| core_hold | output | 1 | 1 while the core must not execute |
| chip_rst | output | 1 | Full-chip reset active |
| cause | output | 2 | Last reset cause: 01 power-up, 10 pin, 11 wake-up |
| dflt_load | output | 7 | Default-state load strobes (order given in R8) |
| wdt_run | output | 1 | Watchdog may count |

## Verification
A counter that is off by one shows as `core_hold` falling one edge early or late. This is visible exactly 1024 edges after the power-up release or the wake request. A wrong cause register or state shows within three edges of a pin event, as a wrong `cause` code, a `chip_rst` level that does not match, or a hold that lingers for a full delay after a pin release. A wake that reaches the chip reset shows on `chip_rst` and `dflt_load` in the cycle after the request.

// File: rtl/startup_reset_pkg.sv
`timescale 1ns/1ps
// Shared types for the reset and start-up delay sequencer.
package startup_reset_pkg;

    // Cause codes reported on the status output.
    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_POR  = 2'b01,
        CAUSE_PIN  = 2'b10,
        CAUSE_WAKE = 2'b11
    } cause_e;

    // Sequencer states.
    typedef enum logic [1:0] {
        ST_RUN   = 2'b00,
        ST_DELAY = 2'b01,
        ST_PIN   = 2'b10
    } seq_state_e;

    localparam int DFLT_BITS = 7;

endpackage

// File: rtl/startup_reset_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser for an active-low asynchronous input.
// Assumes STAGES >= 2. Every flop resets to 1, the inactive level.
module startup_reset_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din_n,
    output logic dout_n
);
    logic [STAGES-1:0] stage_q;

    // First stage samples the asynchronous input.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= 1'b1;
        else        stage_q[0] <= din_n;
    end

    // Each later stage copies the previous one.
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[g] <= 1'b1;
            else        stage_q[g] <= stage_q[g-1];
        end
    end

    assign dout_n = stage_q[STAGES-1];
endmodule

// File: rtl/startup_delay_cnt.sv
`timescale 1ns/1ps
// Start-up delay counter. It clears on clr and otherwise counts up
// while en is high. done flags the last cycle of the window.
// Assumes the controller clears it before it would wrap.
module startup_delay_cnt #(
    parameter int DELAY_CYCLES = 1024,
    localparam int CNT_W = (DELAY_CYCLES > 1) ? $clog2(DELAY_CYCLES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic done
);
    logic [CNT_W-1:0] cnt_q;

    // Count register: clear takes priority over increment.
    always_ff @(posedge clk) begin
        if (!rst_n)  cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else if (en)  cnt_q <= cnt_q + 1'b1;
    end

    assign done = (cnt_q == CNT_W'(DELAY_CYCLES - 1));
endmodule

// File: rtl/startup_reset_ctrl.sv
`timescale 1ns/1ps
// Reset sequencer state machine. The power-on reset enters the delay
// with the chip reset active. The pin reset holds until release and then
// runs at once. A wake request enters the delay with the chip reset idle.
// Assumes pin_n is already synchronised.
module startup_reset_ctrl
    import startup_reset_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pin_n,
    input  logic   wake_req,
    input  logic   cnt_done,
    output logic   cnt_clr,
    output logic   cnt_en,
    output logic   hold,
    output logic   chip_rst,
    output cause_e cause
);
    seq_state_e state_q, state_d;
    logic       rst_q, rst_d;
    cause_e     cause_q, cause_d;

    // Next-state logic: the pin has priority, then wake, then the count.
    always_comb begin
        state_d = state_q;
        rst_d   = rst_q;
        cause_d = cause_q;
        case (state_q)
            ST_RUN: begin
                if (!pin_n) begin
                    state_d = ST_PIN; rst_d = 1'b1; cause_d = CAUSE_PIN;
                end else if (wake_req) begin
                    state_d = ST_DELAY; cause_d = CAUSE_WAKE;
                end
            end
            ST_DELAY: begin
                if (!pin_n) begin
                    state_d = ST_PIN; rst_d = 1'b1; cause_d = CAUSE_PIN;
                end else if (wake_req) begin
                    cause_d = CAUSE_WAKE;
                end else if (cnt_done) begin
                    state_d = ST_RUN; rst_d = 1'b0;
                end
            end
            ST_PIN: begin
                if (pin_n) begin
                    state_d = ST_RUN; rst_d = 1'b0;
                end
            end
            default: begin
                state_d = ST_PIN; rst_d = 1'b1;
            end
        endcase
    end

    // State registers: power-on enters the delay with the chip reset active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_DELAY;
            rst_q   <= 1'b1;
            cause_q <= CAUSE_POR;
        end else begin
            state_q <= state_d;
            rst_q   <= rst_d;
            cause_q <= cause_d;
        end
    end

    // Counter control: count only inside an undisturbed delay window.
    always_comb begin
        cnt_clr = (state_q != ST_DELAY) || !pin_n || wake_req || cnt_done;
        cnt_en  = 1'b1;
    end

    assign hold     = (state_q != ST_RUN);
    assign chip_rst = rst_q;
    assign cause    = cause_q;
endmodule

// File: rtl/startup_reset_seq.sv
`timescale 1ns/1ps
// Top of the reset and start-up delay sequencer. It synchronises the pin,
// runs the delay counter and state machine, and fans the chip reset out
// to the default-load strobes and the watchdog run enable.
// Assumes rst_n is the power-on indication, already synchronous to clk.
module startup_reset_seq
    import startup_reset_pkg::*;
#(
    parameter int DELAY_CYCLES = 1024,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ext_rst_n,
    input  logic                 wake_req,
    output logic                 core_hold,
    output logic                 chip_rst,
    output logic [1:0]           cause,
    output logic [DFLT_BITS-1:0] dflt_load,
    output logic                 wdt_run
);
    logic   pin_sync_n;
    logic   cnt_clr, cnt_en, cnt_done;
    cause_e cause_w;

    startup_reset_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din_n(ext_rst_n), .dout_n(pin_sync_n)
    );

    startup_delay_cnt #(.DELAY_CYCLES(DELAY_CYCLES)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(cnt_en), .done(cnt_done)
    );

    startup_reset_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .pin_n(pin_sync_n), .wake_req(wake_req),
        .cnt_done(cnt_done), .cnt_clr(cnt_clr), .cnt_en(cnt_en),
        .hold(core_hold), .chip_rst(chip_rst), .cause(cause_w)
    );

    assign cause = cause_w;

    // Default-load fan-out: one strobe per block that takes a reset state.
    for (genvar g = 0; g < DFLT_BITS; g++) begin : g_dflt
        assign dflt_load[g] = chip_rst;
    end

    assign wdt_run = ~chip_rst;
endmodule

// File: rtl/startup_reset_seq_chk.sv
`timescale 1ns/1ps
// Assertion checker for startup_reset_seq, attached with bind.
module startup_reset_seq_chk #(
    parameter int DELAY_CYCLES = 1024
) (
    input logic       clk,
    input logic       rst_n,
    input logic       pin_sync_n,
    input logic       wake_req,
    input logic       core_hold,
    input logic       chip_rst,
    input logic [1:0] cause
);
    logic        was_rst = 1'b0;
    logic [31:0] hold_len;

    // Remembers that reset was sampled low on the previous edge.
    always_ff @(posedge clk) was_rst <= !rst_n;

    // Counts consecutive held cycles since reset or since the last run cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !core_hold) hold_len <= 32'd0;
        else if (hold_len < DELAY_CYCLES + 1) hold_len <= hold_len + 32'd1;
    end

    // R1: the power-on reset forces hold, chip reset and the power-up cause.
    always_ff @(posedge clk) begin
        if (was_rst)
            a_r1_reset_state: assert (core_hold && chip_rst && cause == 2'b01);
    end

    a_r3_pin_enters: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_sync_n |=> (chip_rst && core_hold && cause == 2'b10));

    a_r4_pin_release: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_rst && cause == 2'b10 && pin_sync_n) |=> !core_hold);

    a_r5_wake_no_chip_rst: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_hold && wake_req && pin_sync_n) |=> (core_hold && !chip_rst && cause == 2'b11));

    a_r2_min_window: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(core_hold) && cause != 2'b10) |-> (hold_len >= DELAY_CYCLES - 1));
endmodule

bind startup_reset_seq startup_reset_seq_chk #(.DELAY_CYCLES(DELAY_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .pin_sync_n(pin_sync_n), .wake_req(wake_req),
    .core_hold(core_hold), .chip_rst(chip_rst), .cause(cause)
);

// File: tb/startup_reset_seq_test.sv
`timescale 1ns/1ps
module startup_reset_seq_test;
    localparam int DLY = 1024;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_rst_n = 1'b1;
    logic       wake_req = 1'b0;
    logic       core_hold, chip_rst, wdt_run;
    logic [1:0] cause;
    logic [6:0] dflt_load;
    int         n_chk = 0;
    int         n_bad = 0;

    startup_reset_seq uut (
        .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n), .wake_req(wake_req),
        .core_hold(core_hold), .chip_rst(chip_rst), .cause(cause),
        .dflt_load(dflt_load), .wdt_run(wdt_run)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Packs hold, chip reset and cause into one value.
    function automatic int outs();
        return {core_hold, chip_rst, cause};
    endfunction

    // R1, R2, R8: power-on reset state and the full delay window.
    task automatic t_power_up();
        rst_n = 1'b0;
        wait_neg(3);
        chk("R1 reset outputs", outs(), 4'b1101);
        chk("R8 defaults in reset", dflt_load, 7'h7F);
        chk("R8 wdt_run in reset", wdt_run, 0);
        rst_n = 1'b1;
        wait_neg(DLY - 1);
        chk("R2 still held at edge 1023", outs(), 4'b1101);
        wait_neg(1);
        chk("R2 released at edge 1024", outs(), 4'b0001);
        chk("R8 defaults idle", dflt_load, 0);
        chk("R8 wdt_run idle", wdt_run, 1);
    endtask

    // R3, R4: pin reset through the synchroniser, release without delay.
    task automatic t_pin();
        ext_rst_n = 1'b0;
        wait_neg(2);
        chk("R3 not yet seen after 2 edges", outs(), 4'b0001);
        wait_neg(1);
        chk("R3 pin reset at edge 3", outs(), 4'b1110);
        wait_neg(5);
        ext_rst_n = 1'b1;
        wait_neg(2);
        chk("R4 held 2 edges after release", core_hold, 1);
        wait_neg(1);
        chk("R4 released at edge 3", outs(), 4'b0010);
    endtask

    // R5: wake from halt holds the core only.
    task automatic t_wake();
        wake_req = 1'b1;
        wait_neg(1);
        wake_req = 1'b0;
        chk("R5 wake hold", outs(), 4'b1011);
        chk("R5 no chip reset strobes", dflt_load, 0);
        wait_neg(DLY - 1);
        chk("R5 held at edge 1023", core_hold, 1);
        wait_neg(1);
        chk("R5 released at edge 1024", outs(), 4'b0011);
    endtask

    // R6: a second wake in the window restarts the count.
    task automatic t_wake_restart();
        wake_req = 1'b1; wait_neg(1); wake_req = 1'b0;
        wait_neg(500);
        wake_req = 1'b1; wait_neg(1); wake_req = 1'b0;
        wait_neg(DLY - 1);
        chk("R6 held 1023 edges after restart", core_hold, 1);
        wait_neg(1);
        chk("R6 released 1024 edges after restart", core_hold, 0);
    endtask

    // R7: pin reset during the power-up delay abandons the delay.
    task automatic t_pin_abort();
        rst_n = 1'b0; wait_neg(2); rst_n = 1'b1;
        wait_neg(100);
        ext_rst_n = 1'b0;
        wait_neg(3);
        chk("R7 pin takes over delay", outs(), 4'b1110);
        ext_rst_n = 1'b1;
        wait_neg(3);
        chk("R7 released without delay", outs(), 4'b0010);
    endtask

    // R9: pin reset beats a simultaneous wake request.
    task automatic t_pin_over_wake();
        ext_rst_n = 1'b0;
        wait_neg(2);
        wake_req = 1'b1; wait_neg(1); wake_req = 1'b0;
        chk("R9 pin wins over wake", outs(), 4'b1110);
        ext_rst_n = 1'b1;
        wait_neg(3);
        chk("R9 no delay after pin", outs(), 4'b0010);
    endtask

    initial begin
        t_power_up();
        t_pin();
        t_wake();
        t_wake_restart();
        t_pin_abort();
        t_pin_over_wake();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule